// File: doc/BRIEF.md
# NAND Page DMA Transfer Engine

This block moves a single flash page between a byte-wide NAND command/data channel and system memory without any per-byte work from software. A page is split into two regions: the main data area (a fixed number of bytes set by a parameter) and the spare area (length programmable up to 4095 bytes). Each region has its own memory base address. Software writes the two base addresses, the spare length, the row address, the per-area enables and a control word. Setting the control word's start bit then runs the whole job. The engine issues the command and address bytes, waits for the flash to come out of busy, and streams the bytes through a burst request/grant memory port.

On completion the start bit clears itself. If the completion interrupt is enabled, a status bit is set and drives the interrupt line until software writes 1 to the clear register. While a transfer runs, every configuration register is frozen against writes, so the sequencer can use the live register values throughout.

Top module: `nand_page_dma`

## Requirements
- R1: After reset the control register reads 0, the length register reads 0x0080_0000 (spare length 128), `irq` is low and neither `mem_req` nor `fl_out_valid` is asserted.
- R2: Writing the control register (byte offset 0x00) with bit 0 set while idle starts a transfer. Bit 0 reads 1 until the transfer ends and 0 afterwards. Writes to the control, base, length, parameter and row registers are ignored while bit 0 reads 1.
- R3: With control bit 1 clear (flash to memory), the flash channel carries command 0x00, then the address bytes, then command 0x30. The engine then waits for `fl_rdy` high and streams the data. With bit 1 set (memory to flash), it carries command 0x80, the address bytes, the data, and command 0x10, then waits for `fl_rdy` high. `fl_out_kind` is 0 for a command byte, 1 for an address byte and 2 for a data byte.
- R4: Control bit 7 set sends four address bytes: column low, column high, row[7:0], row[15:8]. Bit 7 clear adds a fifth byte, row[23:16]. The column is 0 when the main area is transferred and the page size otherwise.
- R5: The main area is transferred only if control bit 2 and parameter bit 0 are both set. The spare area is transferred only if control bit 3 and parameter bit 1 are both set and the spare length is non-zero. Main bytes use the main base address (offset 0x04) and spare bytes use the spare base address (offset 0x08). The main area completes before the spare area starts.
- R6: Each memory burst is the largest of 16, 8 or 4 beats that is enabled (control bits 6, 5, 4) and does not exceed the bytes left in the current area. Otherwise the burst is a single beat. The burst address advances by the burst length, and a request holds its address and length until granted.
- R7: In a flash-to-memory transfer each memory write beat carries the next flash byte in column order. In a memory-to-flash transfer each flash data byte equals the next memory read beat.
- R8: Completion sets status bit 9 (offset 0x1C) only if enable bit 9 (offset 0x18) is set. `irq` is the AND of status and enable. Writing 1 to bit 9 of offset 0x20 clears the status.
- R9: `fl_cs` equals control bits 9:8.
- R10: The spare length is bits 27:16 of the length register (offset 0x0C) and reads back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 6 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr` |
| irq | output | 1 | Completion interrupt |
| fl_cs | output | 2 | Flash chip select |
| fl_out_valid | output | 1 | Byte offered to the flash |
| fl_out_kind | output | 2 | 0 command, 1 address, 2 data |
| fl_out_byte | output | 8 | Byte to the flash |
| fl_out_ready | input | 1 | Flash accepts the byte |
| fl_in_valid | input | 1 | Flash read byte available |
| fl_in_byte | input | 8 | Flash read byte |
| fl_in_ready | output | 1 | Engine takes the read byte |
| fl_rdy | input | 1 | Flash ready (high) / busy (low) |
| mem_req | output | 1 | Burst request |
| mem_write | output | 1 | Burst writes into memory |
| mem_addr | output | 32 | Burst start address |
| mem_beats | output | 5 | Burst length in byte beats |
| mem_gnt | input | 1 | Burst request accepted |
| mem_wvalid | output | 1 | Write beat valid |
| mem_wdata | output | 8 | Write beat data |
| mem_wready | input | 1 | Memory takes the write beat |
| mem_rvalid | input | 1 | Read beat valid |
| mem_rdata | input | 8 | Read beat data |
| mem_rready | output | 1 | Engine takes the read beat |

## Verification
The assertions assume the memory side grants at most one burst at a time. They also assume it delivers exactly the granted number of beats before the engine asks again, and that the flash pulls `fl_rdy` low no later than the cycle after a closing command byte is accepted. The bench models both sides to match: the memory model answers a request only when no beats are outstanding and counts beats down from the grant, and the flash model drops ready in the cycle after it sees the closing command. The stimulus also throttles `fl_out_ready` and `mem_wready` in a fixed pattern, so every handshake is exercised both with and without stalls.

// File: rtl/ndma_pkg.sv
// Shared definitions for the NAND page DMA engine: register offsets,
// flash opcodes, byte-kind encoding, sequencer states and burst width.
package ndma_pkg;
    localparam int MAX_BURST = 16;
    localparam int BEAT_W    = $clog2(MAX_BURST + 1);

    localparam logic [5:0] RG_CTRL  = 6'h00;
    localparam logic [5:0] RG_MBASE = 6'h04;
    localparam logic [5:0] RG_SBASE = 6'h08;
    localparam logic [5:0] RG_LEN   = 6'h0C;
    localparam logic [5:0] RG_PARA  = 6'h10;
    localparam logic [5:0] RG_ROW   = 6'h14;
    localparam logic [5:0] RG_IEN   = 6'h18;
    localparam logic [5:0] RG_ISTAT = 6'h1C;
    localparam logic [5:0] RG_ICLR  = 6'h20;

    localparam logic [7:0] OP_RD_SETUP = 8'h00;
    localparam logic [7:0] OP_RD_GO    = 8'h30;
    localparam logic [7:0] OP_PG_SETUP = 8'h80;
    localparam logic [7:0] OP_PG_GO    = 8'h10;

    typedef enum logic [1:0] {
        FK_CMD  = 2'd0,
        FK_ADDR = 2'd1,
        FK_DATA = 2'd2
    } fl_kind_e;

    typedef enum logic [2:0] {
        S_IDLE, S_CMD1, S_ADDR, S_CMD2, S_WAIT, S_REQ, S_DATA, S_DONE
    } seq_state_e;
endpackage

// File: rtl/ndma_regs.sv
// Register file and completion interrupt of the page DMA engine.
// Assumes: done is a one-cycle pulse from the sequencer. Configuration
// registers are write-protected while busy so the sequencer may use them live.
module ndma_regs
    import ndma_pkg::*;
#(
    parameter int AW        = 32,
    parameter int SPARE_RST = 128
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [5:0]    cfg_addr,
    input  logic [31:0]   cfg_wdata,
    output logic [31:0]   cfg_rdata,
    input  logic          done,
    output logic          start,
    output logic          busy,
    output logic          ctl_prog,
    output logic          ctl_main,
    output logic          ctl_spare,
    output logic          ctl_b4,
    output logic          ctl_b8,
    output logic          ctl_b16,
    output logic          ctl_addr4,
    output logic [1:0]    ctl_cs,
    output logic [AW-1:0] main_base,
    output logic [AW-1:0] spare_base,
    output logic [11:0]   spare_len,
    output logic [1:0]    para,
    output logic [23:0]   row,
    output logic          irq
);
    logic [9:1] ctrl_q;
    logic       ien_q;
    logic       stat_q;
    logic       cfg_ok;
    logic       unused_wdata;

    assign unused_wdata = ^cfg_wdata;
    assign cfg_ok = cfg_we && !busy;
    assign start  = cfg_ok && (cfg_addr == RG_CTRL) && cfg_wdata[0];

    assign ctl_prog  = ctrl_q[1];
    assign ctl_main  = ctrl_q[2];
    assign ctl_spare = ctrl_q[3];
    assign ctl_b4    = ctrl_q[4];
    assign ctl_b8    = ctrl_q[5];
    assign ctl_b16   = ctrl_q[6];
    assign ctl_addr4 = ctrl_q[7];
    assign ctl_cs    = ctrl_q[9:8];
    assign irq       = stat_q && ien_q;

    // Configuration writes, accepted only while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q     <= '0;
            main_base  <= '0;
            spare_base <= '0;
            spare_len  <= 12'(SPARE_RST);
            para       <= '0;
            row        <= '0;
        end else if (cfg_ok) begin
            case (cfg_addr)
                RG_CTRL:  ctrl_q     <= cfg_wdata[9:1];
                RG_MBASE: main_base  <= cfg_wdata[AW-1:0];
                RG_SBASE: spare_base <= cfg_wdata[AW-1:0];
                RG_LEN:   spare_len  <= cfg_wdata[27:16];
                RG_PARA:  para       <= cfg_wdata[1:0];
                RG_ROW:   row        <= cfg_wdata[23:0];
                default:  ;
            endcase
        end
    end

    // Busy flag: set by the start write, cleared by completion.
    always_ff @(posedge clk) begin
        if (!rst_n)     busy <= 1'b0;
        else if (start) busy <= 1'b1;
        else if (done)  busy <= 1'b0;
    end

    // Interrupt enable and write-1-to-clear status; a set wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ien_q  <= 1'b0;
            stat_q <= 1'b0;
        end else begin
            if (cfg_we && cfg_addr == RG_IEN) ien_q <= cfg_wdata[9];
            if (done && ien_q)
                stat_q <= 1'b1;
            else if (cfg_we && cfg_addr == RG_ICLR && cfg_wdata[9])
                stat_q <= 1'b0;
        end
    end

    // Read-back multiplexer.
    always_comb begin
        cfg_rdata = '0;
        case (cfg_addr)
            RG_CTRL:  cfg_rdata = {22'd0, ctrl_q, busy};
            RG_MBASE: cfg_rdata[AW-1:0] = main_base;
            RG_SBASE: cfg_rdata[AW-1:0] = spare_base;
            RG_LEN:   cfg_rdata = {4'd0, spare_len, 16'd0};
            RG_PARA:  cfg_rdata = {30'd0, para};
            RG_ROW:   cfg_rdata = {8'd0, row};
            RG_IEN:   cfg_rdata = {22'd0, ien_q, 9'd0};
            RG_ISTAT: cfg_rdata = {22'd0, stat_q, 9'd0};
            default:  cfg_rdata = '0;
        endcase
    end

    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !done |=> busy); // R2
    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(ctrl_q) && $stable(spare_len) && $stable(row)); // R2
    AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we && cfg_addr == RG_ICLR && cfg_wdata[9] && !done |=> !irq); // R8
    AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        done && ien_q && !(cfg_we && cfg_addr == RG_IEN) |=> irq); // R8
endmodule

// File: rtl/ndma_burst_pick.sv
// Chooses the burst length for the next memory request: the largest
// enabled size of 4, 8 or 16 that fits in the bytes left, else one beat.
// Assumes rem is non-zero whenever the result is used.
module ndma_burst_pick
    import ndma_pkg::*;
#(
    parameter int REM_W = 13
) (
    input  logic [REM_W-1:0]  rem,
    input  logic              en4,
    input  logic              en8,
    input  logic              en16,
    output logic [BEAT_W-1:0] beats
);
    localparam int NSIZE = 3;

    logic [NSIZE-1:0] fits;
    logic [NSIZE-1:0] ens;

    assign ens = {en16, en8, en4};

    // One comparator per candidate size (4 << i).
    for (genvar i = 0; i < NSIZE; i++) begin : g_fit
        assign fits[i] = ens[i] && (rem >= REM_W'(4 << i));
    end

    // Largest fitting candidate wins.
    always_comb begin
        beats = BEAT_W'(1);
        for (int i = 0; i < NSIZE; i++)
            if (fits[i]) beats = BEAT_W'(4 << i);
    end
endmodule

// File: rtl/ndma_seq.sv
// Page sequencer: issues setup command, address bytes and go command,
// waits for flash ready, and moves the main then spare area in bursts.
// Assumes configuration inputs stay stable while a transfer runs and
// that the memory side delivers exactly the granted number of beats.
module ndma_seq
    import ndma_pkg::*;
#(
    parameter int AW         = 32,
    parameter int PAGE_BYTES = 2048,
    parameter int REM_W      = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              dir_prog,
    input  logic              main_act,
    input  logic              spare_act,
    input  logic              addr4,
    input  logic              en4,
    input  logic              en8,
    input  logic              en16,
    input  logic [23:0]       row,
    input  logic [AW-1:0]     main_base,
    input  logic [AW-1:0]     spare_base,
    input  logic [11:0]       spare_len,
    output logic              done,
    output logic              fl_out_valid,
    output logic [1:0]        fl_out_kind,
    output logic [7:0]        fl_out_byte,
    input  logic              fl_out_ready,
    input  logic              fl_in_valid,
    input  logic [7:0]        fl_in_byte,
    output logic              fl_in_ready,
    input  logic              fl_rdy,
    output logic              mem_req,
    output logic              mem_write,
    output logic [AW-1:0]     mem_addr,
    output logic [BEAT_W-1:0] mem_beats,
    input  logic              mem_gnt,
    output logic              mem_wvalid,
    output logic [7:0]        mem_wdata,
    input  logic              mem_wready,
    input  logic              mem_rvalid,
    input  logic [7:0]        mem_rdata,
    output logic              mem_rready
);
    localparam logic [REM_W-1:0] PAGE_REM  = REM_W'(PAGE_BYTES);
    localparam logic [15:0]      SPARE_COL = 16'(PAGE_BYTES);

    seq_state_e        state;
    logic [2:0]        aidx;
    logic              area;
    logic [REM_W-1:0]  rem;
    logic [AW-1:0]     ptr;
    logic [BEAT_W-1:0] beats_left;
    logic              data_over;
    logic [BEAT_W-1:0] pick;
    logic [15:0]       col;
    logic [2:0]        addr_last;
    logic              in_data;
    logic              beat;

    ndma_burst_pick #(.REM_W(REM_W)) u_pick (
        .rem   (rem),
        .en4   (en4),
        .en8   (en8),
        .en16  (en16),
        .beats (pick)
    );

    assign col       = main_act ? 16'd0 : SPARE_COL;
    assign addr_last = addr4 ? 3'd3 : 3'd4;
    assign in_data   = (state == S_DATA);
    assign beat      = dir_prog ? (mem_rvalid && fl_out_ready)
                                : (fl_in_valid && mem_wready);
    assign done      = (state == S_DONE);

    assign mem_req    = (state == S_REQ);
    assign mem_write  = !dir_prog;
    assign mem_addr   = ptr;
    assign mem_beats  = pick;
    assign mem_wvalid = in_data && !dir_prog && fl_in_valid;
    assign mem_wdata  = fl_in_byte;
    assign fl_in_ready = in_data && !dir_prog && mem_wready;
    assign mem_rready  = in_data && dir_prog && fl_out_ready;

    // Flash output channel: commands, address bytes and program data.
    always_comb begin
        fl_out_valid = 1'b0;
        fl_out_kind  = FK_CMD;
        fl_out_byte  = 8'h00;
        case (state)
            S_CMD1: begin
                fl_out_valid = 1'b1;
                fl_out_byte  = dir_prog ? OP_PG_SETUP : OP_RD_SETUP;
            end
            S_ADDR: begin
                fl_out_valid = 1'b1;
                fl_out_kind  = FK_ADDR;
                case (aidx)
                    3'd0:    fl_out_byte = col[7:0];
                    3'd1:    fl_out_byte = col[15:8];
                    3'd2:    fl_out_byte = row[7:0];
                    3'd3:    fl_out_byte = row[15:8];
                    default: fl_out_byte = row[23:16];
                endcase
            end
            S_CMD2: begin
                fl_out_valid = 1'b1;
                fl_out_byte  = dir_prog ? OP_PG_GO : OP_RD_GO;
            end
            S_DATA: begin
                fl_out_valid = dir_prog && mem_rvalid;
                fl_out_kind  = FK_DATA;
                fl_out_byte  = mem_rdata;
            end
            default: ;
        endcase
    end

    // Sequencer state, area bookkeeping and burst counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= S_IDLE;
            aidx       <= '0;
            area       <= 1'b0;
            rem        <= '0;
            ptr        <= '0;
            beats_left <= '0;
            data_over  <= 1'b0;
        end else begin
            case (state)
                S_IDLE: if (start) state <= S_CMD1;
                S_CMD1: if (fl_out_ready) begin
                    state     <= S_ADDR;
                    aidx      <= '0;
                    area      <= !main_act;
                    rem       <= main_act ? PAGE_REM : REM_W'(spare_len);
                    ptr       <= main_act ? main_base : spare_base;
                    data_over <= !(main_act || spare_act);
                end
                S_ADDR: if (fl_out_ready) begin
                    if (aidx == addr_last)
                        state <= (dir_prog && !data_over) ? S_REQ : S_CMD2;
                    else
                        aidx <= aidx + 3'd1;
                end
                S_CMD2: if (fl_out_ready) state <= S_WAIT;
                S_WAIT: if (fl_rdy)
                    state <= (dir_prog || data_over) ? S_DONE : S_REQ;
                S_REQ: if (mem_gnt) begin
                    beats_left <= pick;
                    state      <= S_DATA;
                end
                S_DATA: if (beat) begin
                    ptr        <= ptr + AW'(1);
                    rem        <= rem - REM_W'(1);
                    beats_left <= beats_left - BEAT_W'(1);
                    if (beats_left == BEAT_W'(1)) begin
                        if (rem == REM_W'(1)) begin
                            if (!area && spare_act) begin
                                area  <= 1'b1;
                                rem   <= REM_W'(spare_len);
                                ptr   <= spare_base;
                                state <= S_REQ;
                            end else begin
                                data_over <= 1'b1;
                                state     <= dir_prog ? S_CMD2 : S_DONE;
                            end
                        end else begin
                            state <= S_REQ;
                        end
                    end
                end
                S_DONE:  state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    AST_BURST_FITS: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (REM_W'(mem_beats) <= rem)); // R6
    AST_BURST_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> $onehot(mem_beats) && !mem_beats[1]); // R6
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_beats)); // R6
    AST_ONE_DIRECTION: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_wvalid && mem_rready)); // R7
    AST_DATA_ONLY_PROG: assert property (@(posedge clk) disable iff (!rst_n)
        fl_out_valid && fl_out_kind == FK_DATA |-> dir_prog); // R3
endmodule

// File: rtl/nand_page_dma.sv
// Top of the NAND page DMA engine: register file, area qualification
// and page sequencer. Assumes a single clock domain and a byte-wide
// memory data path.
module nand_page_dma
    import ndma_pkg::*;
#(
    parameter int AW         = 32,
    parameter int PAGE_BYTES = 2048,
    parameter int SPARE_RST  = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [5:0]        cfg_addr,
    input  logic [31:0]       cfg_wdata,
    output logic [31:0]       cfg_rdata,
    output logic              irq,
    output logic [1:0]        fl_cs,
    output logic              fl_out_valid,
    output logic [1:0]        fl_out_kind,
    output logic [7:0]        fl_out_byte,
    input  logic              fl_out_ready,
    input  logic              fl_in_valid,
    input  logic [7:0]        fl_in_byte,
    output logic              fl_in_ready,
    input  logic              fl_rdy,
    output logic              mem_req,
    output logic              mem_write,
    output logic [AW-1:0]     mem_addr,
    output logic [BEAT_W-1:0] mem_beats,
    input  logic              mem_gnt,
    output logic              mem_wvalid,
    output logic [7:0]        mem_wdata,
    input  logic              mem_wready,
    input  logic              mem_rvalid,
    input  logic [7:0]        mem_rdata,
    output logic              mem_rready
);
    localparam int PG_W  = $clog2(PAGE_BYTES + 1);
    localparam int REM_W = (PG_W > 13) ? PG_W : 13;

    logic          start, busy, done;
    logic          ctl_prog, ctl_main, ctl_spare, ctl_b4, ctl_b8, ctl_b16, ctl_addr4;
    logic [1:0]    ctl_cs;
    logic [AW-1:0] main_base, spare_base;
    logic [11:0]   spare_len;
    logic [1:0]    para;
    logic [23:0]   row;
    logic          main_act, spare_act;

    assign main_act  = ctl_main && para[0];
    assign spare_act = ctl_spare && para[1] && (spare_len != 12'd0);
    assign fl_cs     = ctl_cs;

    ndma_regs #(.AW(AW), .SPARE_RST(SPARE_RST)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_wdata  (cfg_wdata),
        .cfg_rdata  (cfg_rdata),
        .done       (done),
        .start      (start),
        .busy       (busy),
        .ctl_prog   (ctl_prog),
        .ctl_main   (ctl_main),
        .ctl_spare  (ctl_spare),
        .ctl_b4     (ctl_b4),
        .ctl_b8     (ctl_b8),
        .ctl_b16    (ctl_b16),
        .ctl_addr4  (ctl_addr4),
        .ctl_cs     (ctl_cs),
        .main_base  (main_base),
        .spare_base (spare_base),
        .spare_len  (spare_len),
        .para       (para),
        .row        (row),
        .irq        (irq)
    );

    ndma_seq #(.AW(AW), .PAGE_BYTES(PAGE_BYTES), .REM_W(REM_W)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .dir_prog     (ctl_prog),
        .main_act     (main_act),
        .spare_act    (spare_act),
        .addr4        (ctl_addr4),
        .en4          (ctl_b4),
        .en8          (ctl_b8),
        .en16         (ctl_b16),
        .row          (row),
        .main_base    (main_base),
        .spare_base   (spare_base),
        .spare_len    (spare_len),
        .done         (done),
        .fl_out_valid (fl_out_valid),
        .fl_out_kind  (fl_out_kind),
        .fl_out_byte  (fl_out_byte),
        .fl_out_ready (fl_out_ready),
        .fl_in_valid  (fl_in_valid),
        .fl_in_byte   (fl_in_byte),
        .fl_in_ready  (fl_in_ready),
        .fl_rdy       (fl_rdy),
        .mem_req      (mem_req),
        .mem_write    (mem_write),
        .mem_addr     (mem_addr),
        .mem_beats    (mem_beats),
        .mem_gnt      (mem_gnt),
        .mem_wvalid   (mem_wvalid),
        .mem_wdata    (mem_wdata),
        .mem_wready   (mem_wready),
        .mem_rvalid   (mem_rvalid),
        .mem_rdata    (mem_rdata),
        .mem_rready   (mem_rready)
    );

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req && !fl_out_valid); // R2
    AST_CS_FROM_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(fl_cs)); // R9
endmodule

// File: tb/sim_nand_page_dma.sv
`timescale 1ns/1ps
module sim_nand_page_dma;
    localparam int PAGE = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [5:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        irq;
    logic [1:0]  fl_cs;
    logic        fl_out_valid;
    logic [1:0]  fl_out_kind;
    logic [7:0]  fl_out_byte;
    logic        fl_out_ready = 1'b0;
    logic        fl_in_valid = 1'b0;
    logic [7:0]  fl_in_byte = '0;
    logic        fl_in_ready;
    logic        fl_rdy = 1'b1;
    logic        mem_req, mem_write;
    logic [31:0] mem_addr;
    logic [4:0]  mem_beats;
    logic        mem_gnt = 1'b0;
    logic        mem_wvalid;
    logic [7:0]  mem_wdata;
    logic        mem_wready = 1'b0;
    logic        mem_rvalid = 1'b0;
    logic [7:0]  mem_rdata = '0;
    logic        mem_rready;

    always #2.5 clk = ~clk;

    nand_page_dma #(.PAGE_BYTES(PAGE)) u0 (.*);

    int n_chk = 0;
    int n_fail = 0;
    logic [9:0]  q_fl[$];
    logic [36:0] q_req[$];
    logic [7:0]  q_mw[$];
    logic [7:0]  memarr[256];

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] fbyte(input int c);
        return 8'(c * 5 + 1);
    endfunction

    function automatic int pick(input int rem, input bit e4, input bit e8, input bit e16);
        if (e16 && rem >= 16) return 16;
        if (e8 && rem >= 8) return 8;
        if (e4 && rem >= 4) return 4;
        return 1;
    endfunction

    // ---------------- monitor and side models ----------------
    int         cyc = 0;
    bit         f_out, f_in, f_mw, f_gnt, f_mr;
    logic [9:0] s_out;
    logic [7:0] s_mw;
    logic [36:0] s_req;
    bit         s_req_wr;
    int         rdy_cnt, acnt, rd_col, bt_left, bt_idx;
    logic [15:0] cap_col;
    logic [31:0] bt_addr;

    // Pops the scoreboard on every handshake and drives both side models.
    always @(negedge clk) begin
        cyc++;
        if (!rst_n) begin
            f_out = 0; f_in = 0; f_mw = 0; f_gnt = 0; f_mr = 0;
            rdy_cnt = 0; acnt = 0; rd_col = 0; bt_left = 0; bt_idx = 0;
            fl_rdy = 1'b1; mem_gnt = 1'b0; mem_rvalid = 1'b0;
        end else begin
            if (f_out) begin
                if (q_fl.size() == 0) chk(0, "R3 unexpected flash byte", s_out, 0);
                else begin
                    logic [9:0] e;
                    e = q_fl.pop_front();
                    chk(s_out == e, (s_out[9:8] == 2'd2) ? "R7 flash data" :
                        (s_out[9:8] == 2'd1) ? "R4 address byte" : "R3 command", s_out, e);
                end
                if (s_out[9:8] == 2'd0) begin
                    acnt = 0;
                    if (s_out[7:0] == 8'h30 || s_out[7:0] == 8'h10) begin
                        fl_rdy = 1'b0; rdy_cnt = 4; rd_col = int'(cap_col);
                    end
                end else if (s_out[9:8] == 2'd1) begin
                    if (acnt == 0) cap_col[7:0] = s_out[7:0];
                    if (acnt == 1) cap_col[15:8] = s_out[7:0];
                    acnt++;
                end
            end
            if (f_in) rd_col++;
            if (f_mw) begin
                if (q_mw.size() == 0) chk(0, "R7 unexpected memory write", s_mw, 0);
                else begin
                    logic [7:0] e;
                    e = q_mw.pop_front();
                    chk(s_mw == e, "R7 memory write data", s_mw, e);
                end
            end
            if (f_gnt) begin
                mem_gnt = 1'b0;
                if (q_req.size() == 0) chk(0, "R6 unexpected burst", s_req, 0);
                else begin
                    logic [36:0] e;
                    e = q_req.pop_front();
                    chk(s_req == e, "R6 burst address/length", s_req, e);
                end
                if (!s_req_wr) begin
                    bt_left = int'(s_req[4:0]); bt_idx = 0; bt_addr = s_req[36:5];
                end
            end
            if (f_mr) begin bt_left--; bt_idx++; end
            if (rdy_cnt > 0) begin
                rdy_cnt--;
                if (rdy_cnt == 0) fl_rdy = 1'b1;
            end
            fl_out_ready = (cyc % 3) != 0;
            mem_wready   = (cyc % 4) != 1;
            fl_in_valid  = 1'b1;
            fl_in_byte   = fbyte(rd_col);
            mem_rvalid   = bt_left > 0;
            mem_rdata    = memarr[(bt_addr + 32'(bt_idx)) & 32'hFF];
            if (mem_req && !mem_gnt && bt_left == 0 && !f_gnt) mem_gnt = 1'b1;
            #1;
            f_out = fl_out_valid && fl_out_ready;
            s_out = {fl_out_kind, fl_out_byte};
            f_in  = fl_in_valid && fl_in_ready;
            f_mw  = mem_wvalid && mem_wready;
            s_mw  = mem_wdata;
            f_gnt = mem_req && mem_gnt;
            s_req = {mem_addr, mem_beats};
            s_req_wr = mem_write;
            f_mr  = mem_rvalid && mem_rready;
        end
    end

    // ---------------- driver ----------------
    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        cfg_addr = a;
        #1 d = cfg_rdata;
    endtask

    task automatic exp_area(input bit prog, input logic [31:0] base, input int col0,
                            input int len, input bit e4, input bit e8, input bit e16);
        int rem, c, b;
        logic [31:0] a;
        rem = len; a = base; c = col0;
        while (rem > 0) begin
            b = pick(rem, e4, e8, e16);
            q_req.push_back({a, 5'(b)});
            for (int k = 0; k < b; k++) begin
                if (!prog) q_mw.push_back(fbyte(c + k));
                else q_fl.push_back({2'd2, memarr[(a + 32'(k)) & 32'hFF]});
            end
            a = a + 32'(b); c += b; rem -= b;
        end
    endtask

    task automatic exp_xfer(input bit prog, input bit m_on, input bit s_on, input int slen,
                            input bit a4, input bit e4, input bit e8, input bit e16,
                            input logic [23:0] row, input logic [31:0] mb, input logic [31:0] sb);
        int col;
        col = m_on ? 0 : PAGE;
        q_fl.push_back({2'd0, prog ? 8'h80 : 8'h00});
        q_fl.push_back({2'd1, 8'(col)});
        q_fl.push_back({2'd1, 8'(col >> 8)});
        q_fl.push_back({2'd1, row[7:0]});
        q_fl.push_back({2'd1, row[15:8]});
        if (!a4) q_fl.push_back({2'd1, row[23:16]});
        if (!prog) q_fl.push_back({2'd0, 8'h30});
        if (m_on) exp_area(prog, mb, 0, PAGE, e4, e8, e16);
        if (s_on) exp_area(prog, sb, PAGE, slen, e4, e8, e16);
        if (prog) q_fl.push_back({2'd0, 8'h10});
    endtask

    task automatic wait_done();
        logic [31:0] d;
        int n;
        n = 0;
        d = 32'h1;
        while (d[0] && n < 20000) begin rd(6'h00, d); n++; end
        chk(d[0] == 1'b0, "R2 start bit self-clears", d[0], 0);
        repeat (3) @(negedge clk);
        chk(q_fl.size() == 0, "R3 flash sequence complete", q_fl.size(), 0);
        chk(q_req.size() == 0, "R6 all bursts issued", q_req.size(), 0);
        chk(q_mw.size() == 0, "R7 all memory writes seen", q_mw.size(), 0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        logic [31:0] d;
        for (int i = 0; i < 256; i++) memarr[i] = 8'(i * 3 + 7);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd(6'h00, d); chk(d == 32'h0, "R1 control after reset", d, 0);
        rd(6'h0C, d); chk(d == 32'h0080_0000, "R1 spare length after reset", d, 32'h0080_0000);
        chk(irq == 1'b0, "R1 irq after reset", irq, 0);
        chk(mem_req == 1'b0 && fl_out_valid == 1'b0, "R1 outputs idle", {mem_req, fl_out_valid}, 0);

        // Read of both areas, five address bytes, all bursts, chip select 2
        wr(6'h04, 32'h0000_1000);
        wr(6'h08, 32'h0000_2080);
        wr(6'h0C, 32'd13 << 16);
        rd(6'h0C, d); chk(d == (32'd13 << 16), "R10 spare length field", d, 32'd13 << 16);
        wr(6'h10, 32'h3);
        wr(6'h14, 32'h000A_0B0C);
        wr(6'h18, 32'h200);
        exp_xfer(0, 1, 1, 13, 0, 1, 1, 1, 24'h0A0B0C, 32'h1000, 32'h2080);
        wr(6'h00, 32'h27D);
        rd(6'h00, d); chk(d == 32'h27D, "R2 start bit reads 1 while busy", d, 32'h27D);
        chk(fl_cs == 2'd2, "R9 chip select", fl_cs, 2);
        wr(6'h00, 32'h300);
        wr(6'h0C, 32'd5 << 16);
        rd(6'h00, d); chk(d == 32'h27D, "R2 control write ignored while busy", d, 32'h27D);
        rd(6'h0C, d); chk(d == (32'd13 << 16), "R2 length write ignored while busy", d, 32'd13 << 16);
        chk(fl_cs == 2'd2, "R9 chip select unchanged while busy", fl_cs, 2);
        wait_done();
        chk(irq == 1'b1, "R8 irq after completion", irq, 1);
        rd(6'h1C, d); chk(d == 32'h200, "R8 status bit set", d, 32'h200);
        wr(6'h20, 32'h200);
        rd(6'h1C, d); chk(d == 32'h0, "R8 status cleared by write 1", d, 0);
        chk(irq == 1'b0, "R8 irq cleared", irq, 0);

        // Spare-only read (main blocked by parameter bit 0), four address bytes, burst 4 only
        wr(6'h10, 32'h2);
        exp_xfer(0, 0, 1, 13, 1, 1, 0, 0, 24'h0A0B0C, 32'h1000, 32'h2080);
        wr(6'h00, 32'h19D);
        chk(fl_cs == 2'd1, "R9 chip select 1", fl_cs, 1);
        wait_done();
        chk(irq == 1'b1, "R5 spare-only transfer completes with irq", irq, 1);
        wr(6'h20, 32'h200);

        // Program of both areas, burst 8 only, interrupt disabled
        wr(6'h18, 32'h0);
        wr(6'h10, 32'h3);
        wr(6'h0C, 32'd6 << 16);
        exp_xfer(1, 1, 1, 6, 0, 0, 1, 0, 24'h0A0B0C, 32'h1000, 32'h2080);
        wr(6'h00, 32'h2F);
        wait_done();
        rd(6'h1C, d); chk(d == 32'h0, "R8 no status when enable clear", d, 0);
        chk(irq == 1'b0, "R8 irq stays low when disabled", irq, 0);

        // No area enabled: command and address only, column points at the spare area
        wr(6'h18, 32'h200);
        exp_xfer(0, 0, 0, 0, 0, 0, 0, 0, 24'h0A0B0C, 32'h1000, 32'h2080);
        wr(6'h00, 32'h01);
        wait_done();
        chk(irq == 1'b1, "R5 empty transfer still completes", irq, 1);

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule